// File: doc/BRIEF.md
# Serial Flash Status Register Reader

This block fetches one 8-bit status register from a serial NOR flash on an SPI bus that other masters share. A one-cycle start pulse begins a read. A select input picks one of two status-read opcodes: 05h when the select is 0 and 35h when it is 1. The block first raises a request to the shared bus arbiter and waits for its one-cycle grant pulse. Only then does it drive chip select, serial clock and serial data out.

It shifts the opcode out and shifts eight status bits in, using SPI mode 0. It then drops its request and waits for the arbiter's second one-cycle pulse, which acknowledges the release. Only after that acknowledge does it present the captured byte with a one-cycle done pulse. In the following cycle it issues either a busy pulse or a ready pulse, depending on the flash's write-in-progress bit.

Top module: `flash_status_reader`

## Requirements
- R1: After reset and whenever no transfer is running, chip select is 1, the serial clock is 0, serial data out is 1, and the bus request, done, busy and ready outputs are all 0.
- R2: One cycle after an accepted start pulse, the bus request is 1. Chip select stays 1 until a grant pulse arrives, however long the arbiter waits.
- R3: The opcode goes out MSB first and is stable at every rising serial-clock edge. It is 05h when the select input sampled with the start pulse is 0, and 35h when it is 1.
- R4: Each serial-clock period lasts CLK_DIV system clocks (default 4), low half first. Chip select stays low for exactly 16 serial-clock periods, which is 16*CLK_DIV system clocks, and the frame contains exactly 16 rising edges.
- R5: The eight bits sampled on rising edges 9 to 16 form the status byte, first bit in at bit 7. The byte appears on the status output together with a single-cycle done pulse, and it holds until the next done pulse.
- R6: The bus request falls one cycle after chip select returns high. Done stays 0 until the release-acknowledge pulse, and rises in the cycle after that pulse is sampled.
- R7: In the cycle after done, exactly one result pulse fires for one cycle. Busy fires when status bit 0 is 1, and ready fires when status bit 0 is 0.
- R8: A start pulse that arrives while a read is in progress is ignored. No second request or transfer follows it.
- R9: A grant or acknowledge pulse that arrives while the block is idle or shifting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that begins a status read |
| sel_i | input | 1 | Opcode select, sampled with start_i: 0 sends 05h, 1 sends 35h |
| bus_req_o | output | 1 | Shared-bus request level |
| bus_ack_i | input | 1 | One-cycle arbiter pulse: a grant while requesting, an acknowledge after release |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_sclk_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| done_o | output | 1 | One-cycle pulse when the status byte is valid |
| status_o | output | 8 | Captured status byte |
| busy_o | output | 1 | One-cycle pulse: the flash reported busy |
| ready_o | output | 1 | One-cycle pulse: the flash reported ready |

## Verification
The assertions assume that the arbiter sends its grant and acknowledge as single-cycle pulses, and only while this block's request is high or has just been dropped. They also assume that start is a single-cycle pulse. The stimulus honours these assumptions in the main sweep and breaks them only on purpose: it sends stray pulses while the block is idle or shifting, and such pulses must have no effect. The sweep covers every status byte with both opcodes, and it varies the grant and acknowledge delays, so the busy and ready split is exercised for every value of bit 0.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2,
      ST_REL  = 2'd3
   } fsr_state_t;
endpackage

// File: rtl/fsr_seq.sv
module fsr_seq
   import fsr_pkg::*;
#(
   parameter int          OP_W   = 8,
   parameter int          STAT_W = 8,
   parameter logic [7:0]  OPC_A  = 8'h05,
   parameter logic [7:0]  OPC_B  = 8'h35
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              sel_i,
   input  logic              ack_i,
   input  logic              fin_i,
   input  logic [STAT_W-1:0] rx_i,
   output logic              bus_req_o,
   output logic              go_o,
   output logic [OP_W-1:0]   opc_o,
   output logic              done_o,
   output logic [STAT_W-1:0] status_o
);
   fsr_state_t st;

   assign bus_req_o = (st == ST_REQ) || (st == ST_XFER);

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         go_o     <= 1'b0;
         done_o   <= 1'b0;
         opc_o    <= OPC_A[OP_W-1:0];
         status_o <= '0;
      end else begin
         go_o   <= 1'b0;
         done_o <= 1'b0;
         case (st)
            ST_IDLE: if (start_i) begin
               opc_o <= sel_i ? OPC_B[OP_W-1:0] : OPC_A[OP_W-1:0];
               st    <= ST_REQ;
            end
            ST_REQ: if (ack_i) begin
               go_o <= 1'b1;
               st   <= ST_XFER;
            end
            ST_XFER: if (fin_i) st <= ST_REL;
            ST_REL: if (ack_i) begin
               done_o   <= 1'b1;
               status_o <= rx_i;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fsr_shift.sv
module fsr_shift #(
   parameter int CLK_DIV = 4,
   parameter int OP_W    = 8,
   parameter int STAT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go_i,
   input  logic [OP_W-1:0]   opc_i,
   input  logic              miso_i,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              fin_o,
   output logic [STAT_W-1:0] rx_o
);
   localparam int FRAME = OP_W + STAT_W;
   localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int BC_W  = $clog2(FRAME);
   localparam logic [PH_W-1:0] PH_RISE = PH_W'(CLK_DIV/2 - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
   localparam logic [BC_W-1:0] BC_RX   = BC_W'(OP_W);
   localparam logic [BC_W-1:0] BC_END  = BC_W'(FRAME - 1);

   logic            act;
   logic [PH_W-1:0] ph;
   logic [BC_W-1:0] bc;
   logic [OP_W-1:0] tx;

   always_ff @(posedge clk) begin
      if (rst) begin
         act    <= 1'b0;
         ph     <= '0;
         bc     <= '0;
         tx     <= '1;
         cs_n_o <= 1'b1;
         sclk_o <= 1'b0;
         mosi_o <= 1'b1;
         fin_o  <= 1'b0;
         rx_o   <= '0;
      end else begin
         fin_o <= 1'b0;
         if (go_i && !act) begin
            act    <= 1'b1;
            ph     <= '0;
            bc     <= '0;
            cs_n_o <= 1'b0;
            sclk_o <= 1'b0;
            mosi_o <= opc_i[OP_W-1];
            tx     <= {opc_i[OP_W-2:0], 1'b1};
         end else if (act) begin
            ph <= ph + PH_W'(1);
            if (ph == PH_RISE) begin
               sclk_o <= 1'b1;
               if (bc >= BC_RX) rx_o <= {rx_o[STAT_W-2:0], miso_i};
            end
            if (ph == PH_LAST) begin
               ph     <= '0;
               sclk_o <= 1'b0;
               if (bc == BC_END) begin
                  act    <= 1'b0;
                  cs_n_o <= 1'b1;
                  mosi_o <= 1'b1;
                  fin_o  <= 1'b1;
               end else begin
                  bc     <= bc + BC_W'(1);
                  mosi_o <= tx[OP_W-1];
                  tx     <= {tx[OP_W-2:0], 1'b1};
               end
            end
         end
      end
   end
endmodule

// File: rtl/fsr_class.sv
module fsr_class #(
   parameter int STAT_W   = 8,
   parameter int BUSY_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done_i,
   input  logic [STAT_W-1:0] status_i,
   output logic              busy_o,
   output logic              ready_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         busy_o  <= 1'b0;
         ready_o <= 1'b0;
      end else begin
         busy_o  <= done_i &&  status_i[BUSY_BIT];
         ready_o <= done_i && !status_i[BUSY_BIT];
      end
   end
endmodule

// File: rtl/flash_status_reader.sv
module flash_status_reader #(
   parameter int         CLK_DIV  = 4,
   parameter int         OP_W     = 8,
   parameter int         STAT_W   = 8,
   parameter int         BUSY_BIT = 0,
   parameter logic [7:0] OPC_A    = 8'h05,
   parameter logic [7:0] OPC_B    = 8'h35
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              sel_i,
   output logic              bus_req_o,
   input  logic              bus_ack_i,
   output logic              spi_cs_n_o,
   output logic              spi_sclk_o,
   output logic              spi_mosi_o,
   input  logic              spi_miso_i,
   output logic              done_o,
   output logic [STAT_W-1:0] status_o,
   output logic              busy_o,
   output logic              ready_o
);
   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (OP_W < 2 || OP_W > 8) begin : g_bad_op
         $error("OP_W must lie in 2..8");
      end
      if (STAT_W < 2 || BUSY_BIT >= STAT_W || BUSY_BIT < 0) begin : g_bad_stat
         $error("STAT_W must be at least 2 and hold BUSY_BIT");
      end
   endgenerate

   logic              go;
   logic              fin;
   logic [OP_W-1:0]   opc;
   logic [STAT_W-1:0] rx;

   fsr_seq #(.OP_W(OP_W), .STAT_W(STAT_W), .OPC_A(OPC_A), .OPC_B(OPC_B)) u_seq (
      .clk(clk), .rst(rst), .start_i(start_i), .sel_i(sel_i), .ack_i(bus_ack_i),
      .fin_i(fin), .rx_i(rx), .bus_req_o(bus_req_o), .go_o(go), .opc_o(opc),
      .done_o(done_o), .status_o(status_o)
   );

   fsr_shift #(.CLK_DIV(CLK_DIV), .OP_W(OP_W), .STAT_W(STAT_W)) u_shift (
      .clk(clk), .rst(rst), .go_i(go), .opc_i(opc), .miso_i(spi_miso_i),
      .cs_n_o(spi_cs_n_o), .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o),
      .fin_o(fin), .rx_o(rx)
   );

   fsr_class #(.STAT_W(STAT_W), .BUSY_BIT(BUSY_BIT)) u_class (
      .clk(clk), .rst(rst), .done_i(done_o), .status_i(status_o),
      .busy_o(busy_o), .ready_o(ready_o)
   );
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk #(
   parameter int STAT_W   = 8,
   parameter int BUSY_BIT = 0
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_req_o,
   input logic              bus_ack_i,
   input logic              spi_cs_n_o,
   input logic              spi_sclk_o,
   input logic              spi_mosi_o,
   input logic              done_o,
   input logic [STAT_W-1:0] status_o,
   input logic              busy_o,
   input logic              ready_o
);
   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
      spi_cs_n_o |-> (!spi_sclk_o && spi_mosi_o));
   // R2
   cs_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      !spi_cs_n_o |-> bus_req_o);
   // R6
   req_drop_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(spi_cs_n_o) |=> $fell(bus_req_o));
   // R6
   done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!bus_req_o && $past(bus_ack_i)));
   // R7
   result_split_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> ((busy_o == status_o[BUSY_BIT]) && (ready_o != status_o[BUSY_BIT])));
   // R7
   pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({done_o, busy_o, ready_o}));
   // R5
   status_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !done_o |=> (!done_o -> $stable(status_o)));
endmodule

bind flash_status_reader fsr_chk #(.STAT_W(STAT_W), .BUSY_BIT(BUSY_BIT)) u_fsr_chk (
   .clk(clk), .rst(rst), .bus_req_o(bus_req_o), .bus_ack_i(bus_ack_i),
   .spi_cs_n_o(spi_cs_n_o), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o),
   .done_o(done_o), .status_o(status_o), .busy_o(busy_o), .ready_o(ready_o)
);

// File: tb/tb_flash_status_reader.sv
module tb_flash_status_reader;
   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0, sel = 1'b0, ack = 1'b0;
   logic req, cs_n, sclk, mosi, miso, done, busy, ready;
   logic [7:0] status;

   int total = 0, bad = 0;
   int cs_low = 0;
   int rcnt = 0, fcnt = 0;
   logic [7:0] mdl_op = 8'h00;
   logic [7:0] mdl_stat = 8'h00;
   logic drv = 1'b1;

   always #4 clk = ~clk;

   flash_status_reader #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst(rst), .start_i(start), .sel_i(sel), .bus_req_o(req),
      .bus_ack_i(ack), .spi_cs_n_o(cs_n), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
      .spi_miso_i(miso), .done_o(done), .status_o(status), .busy_o(busy),
      .ready_o(ready)
   );

   // Flash model: mode 0, samples on rising SCLK, drives on falling SCLK
   assign miso = cs_n ? 1'b1 : drv;
   always @(negedge cs_n) begin
      rcnt <= 0; fcnt <= 0; drv <= 1'b1;
   end
   always @(posedge sclk) begin
      if (rcnt < 8) mdl_op <= {mdl_op[6:0], mosi};
      rcnt <= rcnt + 1;
   end
   always @(negedge sclk) begin
      if (fcnt + 1 >= 8 && fcnt + 1 < 16) drv <= mdl_stat[15 - (fcnt + 1)];
      fcnt <= fcnt + 1;
   end
   always @(posedge clk) if (!cs_n) cs_low <= cs_low + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input logic s, input logic [7:0] v, input int gd, input int rd,
                      input bit inject);
      mdl_stat = v;
      cs_low = 0;
      @(negedge clk); start = 1'b1; sel = s;
      @(negedge clk); start = 1'b0;
      chk(req == 1'b1, "R2 request raised", req, 1);
      for (int k = 0; k < gd; k++) begin
         @(negedge clk);
         chk(cs_n == 1'b1, "R2 no SPI before grant", cs_n, 1);
      end
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      while (cs_n) @(negedge clk);
      if (inject) begin
         repeat (10) @(negedge clk);
         start = 1'b1; ack = 1'b1;
         @(negedge clk); start = 1'b0; ack = 1'b0;
         chk(cs_n == 1'b0 && req == 1'b1, "R9 stray ack during shift", cs_n, 0);
      end
      while (!cs_n) @(negedge clk);
      chk(cs_low == 16*DIV, "R4 chip select low length", cs_low, 16*DIV);
      chk(rcnt == 16, "R4 rising edge count", rcnt, 16);
      chk(mdl_op == (s ? 8'h35 : 8'h05), "R3 opcode", mdl_op, s ? 8'h35 : 8'h05);
      chk(req == 1'b1, "R6 request still high at cs rise", req, 1);
      @(negedge clk);
      chk(req == 1'b0, "R6 request dropped", req, 0);
      for (int k = 0; k < rd; k++) begin
         @(negedge clk);
         chk(done == 1'b0, "R6 no done before release ack", done, 0);
      end
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      chk(done == 1'b1, "R5 done pulse", done, 1);
      chk(status == v, "R5 status byte", status, v);
      @(negedge clk);
      chk(done == 1'b0, "R5 done one cycle", done, 0);
      chk(busy == v[0], "R7 busy pulse", busy, v[0]);
      chk(ready == !v[0], "R7 ready pulse", ready, !v[0]);
      @(negedge clk);
      chk(!busy && !ready && status == v, "R7 result one cycle", {busy, ready}, 0);
      if (inject) begin
         repeat (3) begin
            @(negedge clk);
            chk(req == 1'b0 && cs_n == 1'b1, "R8 start during read ignored", req, 0);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 idle state
      chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b1, "R1 idle lines", {cs_n, sclk, mosi}, 3'b101);
      chk(!req && !done && !busy && !ready, "R1 idle outputs", {req, done, busy, ready}, 0);
      // R9 stray ack while idle
      ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      repeat (2) begin
         @(negedge clk);
         chk(!req && cs_n && !done, "R9 stray ack idle", {req, cs_n, done}, 3'b010);
      end
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 256; v++) begin
            run(s[0], v[7:0], v % 4, 1 + (v % 3), (v % 16) == 5);
         end
      end
      @(negedge clk);
      chk(cs_n && !sclk && mosi && !req, "R1 idle after sweep", {cs_n, sclk, mosi, req}, 4'b1010);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule